// File: doc/BRIEF.md
# Radio Transmit Start Sequencer

This block decides when a packet radio's transmitter begins a frame and brings up the power amplifier path in a controlled order. A start request can come from either of two sources. One is a rising edge on an asynchronous trigger pin, which is synchronized into the system clock domain first. The other is a start command byte written to the state/command register. The block acts on a start only while the transceiver sits in one of two ready states: plain synthesizer-locked ready, or ready for automatic-retry transmission. An accepted start moves it into a busy-transmit state. Any start that arrives elsewhere is dropped and flagged by a one-cycle rejection pulse.

Once busy, a timer counts clock cycles from the moment of acceptance. The amplifier buffer enable comes up first, then the amplifier enable, and finally the modulation-enable strobe. Each threshold is a microsecond figure multiplied by the clock frequency in MHz. The defaults are 4, 8 and 16 µs at 16 MHz, which is 64, 128 and 256 cycles. A frame-done input shuts the path down in reverse order and sends the state back to the ready state it started from. A second register holds the transmit output power setting and drives it onto a port.

Register access is a single-cycle byte write strobe plus a combinational read of the addressed register. Address 0x02 is the state/command register: a write carries a command, and a read returns the current state code in bits [4:0]. Address 0x05 holds the power setting in bits [3:0].

Top module: `tx_start_seq`

## Requirements
- R1: After reset the state reads 0x08 (off), `bufEn`, `ampEn`, `modEn` and `rejected` are low and `txPower` is 0.
- R2: Writing byte 0x09, 0x19 or 0x08 to address 0x02 outside the busy states makes the state read 0x09 (PLL-ready), 0x19 (retry-ready) or 0x08 (off) after that edge. The same writes during a busy state leave the state unchanged.
- R3: Writing byte 0x02 (start) to address 0x02 in a ready state is accepted on that write edge. The state then reads 0x02 if it came from PLL-ready and 0x12 if it came from retry-ready.
- R4: A rising edge on `trigPin` is accepted on the third clock edge after the pin rises, with the state unchanged after the second. A pin that stays high starts nothing further.
- R5: Counting clock edges from the acceptance edge, `bufEn` rises after CLK_MHZ*BUF_US edges, `ampEn` after CLK_MHZ*AMP_US edges and `modEn` after CLK_MHZ*MOD_US edges. All three then stay high until frame done.
- R6: `ampEn` is never high without `bufEn`, and `modEn` is never high without `ampEn`.
- R7: A start request in the off state or in a busy state is not acted on. `rejected` is high for the cycle after the request edge and the state code does not change.
- R8: When `frameDone` is high on a busy-state edge, `ampEn` and `modEn` are low after that edge while `bufEn` keeps its level. One edge later `bufEn` is low and the state reads the originating ready code. `frameDone` outside a busy state has no effect.
- R9: Address 0x05 bits [3:0] hold the power setting. It is written by a byte write, read back with bits [7:4] as zero, and driven on `txPower`. Writes to other addresses leave it unchanged.
- R10: A pin edge and a start command that reach the acceptance edge together give exactly one start, with `rejected` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigPin | input | 1 | Asynchronous start trigger pin |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register address for write and read |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data of the addressed register |
| frameDone | input | 1 | End of frame, begins shutdown of the amplifier path |
| bufEn | output | 1 | Amplifier buffer enable |
| ampEn | output | 1 | Power amplifier enable |
| modEn | output | 1 | Modulation enable |
| rejected | output | 1 | One-cycle pulse for an ignored start request |
| txPower | output | PWR_W | Transmit power setting |

## Verification
The two start sources can reach the acceptance edge in the same cycle. The bench arranges this by raising the pin and then issuing the start command write exactly two edges later, so both arrive on the third edge. It judges the outcome as a single start with no rejection pulse and a ramp whose timing matches a single-source start. A second coincidence is a start request landing on a busy-state edge. The bench checks that this request is rejected without disturbing the running ramp.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  localparam logic [7:0] ADDR_STATE = 8'h02;
  localparam logic [7:0] ADDR_PWR   = 8'h05;

  localparam logic [4:0] CODE_OFF        = 5'h08;
  localparam logic [4:0] CODE_PLL_READY  = 5'h09;
  localparam logic [4:0] CODE_RETRY_RDY  = 5'h19;
  localparam logic [4:0] CODE_BUSY       = 5'h02;
  localparam logic [4:0] CODE_BUSY_RETRY = 5'h12;

  localparam logic [4:0] CMD_START = 5'h02;
  localparam logic [4:0] CMD_OFF   = 5'h08;
  localparam logic [4:0] CMD_PLL   = 5'h09;
  localparam logic [4:0] CMD_RETRY = 5'h19;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_READY,
    MODE_BUSY,
    MODE_DOWN
  } seqMode_t;

  typedef struct packed {
    logic clearTimer;
    logic timing;
    logic rampDown;
  } seqStrobes_t;

endpackage

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinEdge,
  input  logic        cmdValid,
  input  logic [4:0]  cmdCode,
  input  logic        frameDone,
  output seqStrobes_t strobes,
  output logic [4:0]  stateCode,
  output logic        rejected
);

  seqMode_t mode;
  logic     fromRetry;
  logic     startReq;

  assign startReq = pinEdge | (cmdValid && cmdCode == CMD_START);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_OFF;
      fromRetry <= 1'b0;
      rejected  <= 1'b0;
    end else begin
      rejected <= 1'b0;
      unique case (mode)
        MODE_OFF, MODE_READY: begin
          if (startReq) begin
            if (mode == MODE_READY) mode <= MODE_BUSY;
            else                    rejected <= 1'b1;
          end else if (cmdValid) begin
            if (cmdCode == CMD_PLL) begin
              mode      <= MODE_READY;
              fromRetry <= 1'b0;
            end else if (cmdCode == CMD_RETRY) begin
              mode      <= MODE_READY;
              fromRetry <= 1'b1;
            end else if (cmdCode == CMD_OFF) begin
              mode      <= MODE_OFF;
            end
          end
        end
        MODE_BUSY: begin
          if (startReq)  rejected <= 1'b1;
          if (frameDone) mode <= MODE_DOWN;
        end
        MODE_DOWN: begin
          if (startReq) rejected <= 1'b1;
          mode <= MODE_READY;
        end
        default: mode <= MODE_OFF;
      endcase
    end
  end

  always_comb begin
    strobes.clearTimer = (mode == MODE_OFF) || (mode == MODE_READY);
    strobes.timing     = (mode == MODE_BUSY);
    strobes.rampDown   = (mode == MODE_DOWN);
    unique case (mode)
      MODE_OFF:   stateCode = CODE_OFF;
      MODE_READY: stateCode = fromRetry ? CODE_RETRY_RDY : CODE_PLL_READY;
      default:    stateCode = fromRetry ? CODE_BUSY_RETRY : CODE_BUSY;
    endcase
  end

endmodule

// File: rtl/txseq_dpath.sv
module txseq_dpath
  import txseq_pkg::*;
#(
  parameter int CLK_MHZ     = 16,
  parameter int BUF_US      = 4,
  parameter int AMP_US      = 8,
  parameter int MOD_US      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PWR_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigPin,
  input  logic             wrEn,
  input  logic [7:0]       addr,
  input  logic [7:0]       wrData,
  input  seqStrobes_t      strobes,
  input  logic [4:0]       stateCode,
  output logic             pinEdge,
  output logic             cmdValid,
  output logic [4:0]       cmdCode,
  output logic             bufEn,
  output logic             ampEn,
  output logic             modEn,
  output logic [PWR_W-1:0] txPower,
  output logic [7:0]       rdData
);

  localparam int BUF_CYC = CLK_MHZ * BUF_US;
  localparam int AMP_CYC = CLK_MHZ * AMP_US;
  localparam int MOD_CYC = CLK_MHZ * MOD_US;
  localparam int CNT_W   = $clog2(MOD_CYC + 1);
  localparam logic [CNT_W-1:0] BUF_C = CNT_W'(BUF_CYC);
  localparam logic [CNT_W-1:0] AMP_C = CNT_W'(AMP_CYC);
  localparam logic [CNT_W-1:0] MOD_C = CNT_W'(MOD_CYC);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [CNT_W-1:0]       timer;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[i] <= 1'b0;
      else if (i == 0) syncQ[i] <= trigPin;
      else             syncQ[i] <= syncQ[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign pinEdge  = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign cmdValid = wrEn && addr == ADDR_STATE && wrData[7:5] == 3'b000;
  assign cmdCode  = wrData[4:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                timer <= '0;
    else if (strobes.clearTimer)              timer <= '0;
    else if (strobes.timing && timer != MOD_C) timer <= timer + 1'b1;
  end

  assign bufEn = (strobes.timing | strobes.rampDown) && timer >= BUF_C;
  assign ampEn = strobes.timing && timer >= AMP_C;
  assign modEn = strobes.timing && timer >= MOD_C;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            txPower <= '0;
    else if (wrEn && addr == ADDR_PWR)    txPower <= wrData[PWR_W-1:0];
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_STATE)    rdData[4:0]       = stateCode;
    else if (addr == ADDR_PWR) rdData[PWR_W-1:0] = txPower;
  end

endmodule

// File: rtl/tx_start_seq.sv
module tx_start_seq
  import txseq_pkg::*;
#(
  parameter int CLK_MHZ     = 16,
  parameter int BUF_US      = 4,
  parameter int AMP_US      = 8,
  parameter int MOD_US      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PWR_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigPin,
  input  logic             wrEn,
  input  logic [7:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             frameDone,
  output logic             bufEn,
  output logic             ampEn,
  output logic             modEn,
  output logic             rejected,
  output logic [PWR_W-1:0] txPower
);

  seqStrobes_t strobes;
  logic [4:0]  stateCode;
  logic        pinEdge;
  logic        cmdValid;
  logic [4:0]  cmdCode;

  txseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinEdge(pinEdge), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .frameDone(frameDone), .strobes(strobes),
    .stateCode(stateCode), .rejected(rejected)
  );

  txseq_dpath #(
    .CLK_MHZ(CLK_MHZ), .BUF_US(BUF_US), .AMP_US(AMP_US), .MOD_US(MOD_US),
    .SYNC_STAGES(SYNC_STAGES), .PWR_W(PWR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .strobes(strobes), .stateCode(stateCode),
    .pinEdge(pinEdge), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .bufEn(bufEn), .ampEn(ampEn), .modEn(modEn), .txPower(txPower),
    .rdData(rdData)
  );

endmodule

// File: rtl/tx_start_seq_chk.sv
module tx_start_seq_chk
  import txseq_pkg::*;
#(
  parameter int PWR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             bufEn,
  input logic             ampEn,
  input logic             modEn,
  input logic             wrEn,
  input logic [7:0]       addr,
  input logic [PWR_W-1:0] txPower,
  input logic [4:0]       stateCode
);

  AST_AMP_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    ampEn |-> bufEn); // R6
  AST_MOD_NEEDS_AMP: assert property (@(posedge clk) disable iff (!rstN)
    modEn |-> ampEn); // R6
  AST_BUF_DROPS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEn) |-> $past(!ampEn)); // R8
  AST_ENABLES_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    bufEn |-> (stateCode == CODE_BUSY || stateCode == CODE_BUSY_RETRY)); // R5
  AST_POWER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_PWR) |=> $stable(txPower)); // R9

endmodule

bind tx_start_seq tx_start_seq_chk #(.PWR_W(PWR_W)) u_chk (
  .clk(clk), .rstN(rstN), .bufEn(bufEn), .ampEn(ampEn), .modEn(modEn),
  .wrEn(wrEn), .addr(addr), .txPower(txPower), .stateCode(stateCode)
);

// File: tb/test_tx_start_seq.sv
module test_tx_start_seq;

  localparam int CLK_MHZ = 2;
  localparam int BUF_US  = 4;
  localparam int AMP_US  = 8;
  localparam int MOD_US  = 16;
  localparam int PWR_W   = 4;
  localparam int BUF_EXP = CLK_MHZ * BUF_US;
  localparam int AMP_EXP = CLK_MHZ * AMP_US;
  localparam int MOD_EXP = CLK_MHZ * MOD_US;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigPin = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic frameDone = 1'b0;
  logic bufEn, ampEn, modEn, rejected;
  logic [PWR_W-1:0] txPower;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tx_start_seq #(
    .CLK_MHZ(CLK_MHZ), .BUF_US(BUF_US), .AMP_US(AMP_US), .MOD_US(MOD_US),
    .SYNC_STAGES(2), .PWR_W(PWR_W)
  ) i_tx_start_seq (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .frameDone(frameDone),
    .bufEn(bufEn), .ampEn(ampEn), .modEn(modEn), .rejected(rejected),
    .txPower(txPower)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic measureRamp(input string tag);
    int bufAt = -1;
    int ampAt = -1;
    int modAt = -1;
    bit orderOk = 1'b1;
    for (int k = 0; k <= MOD_EXP + 3; k++) begin
      if (bufEn && bufAt < 0) bufAt = k;
      if (ampEn && ampAt < 0) ampAt = k;
      if (modEn && modAt < 0) modAt = k;
      if ((ampEn && !bufEn) || (modEn && !ampEn)) orderOk = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    check(bufAt == BUF_EXP, {"R5 buffer ", tag}, bufAt, BUF_EXP);
    check(ampAt == AMP_EXP, {"R5 amp ", tag}, ampAt, AMP_EXP);
    check(modAt == MOD_EXP, {"R5 mod ", tag}, modAt, MOD_EXP);
    check(orderOk, {"R6 order ", tag}, orderOk, 1);
    check(bufEn && ampEn && modEn, {"R5 held ", tag}, {bufEn, ampEn, modEn}, 7);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] readyCode, busyCode, goCmd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(8'h02, v);
    check(v == 8'h08, "R1 state", v, 8'h08);
    check(!bufEn && !ampEn && !modEn && !rejected, "R1 outputs",
          {bufEn, ampEn, modEn, rejected}, 0);
    check(txPower == 0, "R1 power", txPower, 0);

    // R7 start from off
    writeReg(8'h02, 8'h02);
    check(rejected == 1'b1, "R7 pulse in off", rejected, 1);
    readReg(8'h02, v);
    check(v == 8'h08, "R7 state kept", v, 8'h08);
    @(posedge clk); @(negedge clk);
    check(rejected == 1'b0, "R7 pulse width", rejected, 0);

    // R9 power sweep
    for (int p = 0; p < 16; p++) begin
      writeReg(8'h05, {4'hA, p[3:0]});
      readReg(8'h05, v);
      check(v == {4'h0, p[3:0]}, "R9 readback", v, p);
      check(txPower == p[3:0], "R9 port", txPower, p);
    end
    writeReg(8'h03, 8'hF3);
    check(txPower == 4'hF, "R9 other address", txPower, 15);

    for (int org = 0; org < 2; org++) begin
      for (int src = 0; src < 3; src++) begin
        goCmd     = org ? 8'h19 : 8'h09;
        readyCode = org ? 8'h19 : 8'h09;
        busyCode  = org ? 8'h12 : 8'h02;
        writeReg(8'h02, goCmd);
        readReg(8'h02, v);
        check(v == readyCode, "R2 go ready", v, readyCode);

        if (src == 0) begin
          writeReg(8'h02, 8'h02);
          readReg(8'h02, v);
          check(v == busyCode, "R3 command start", v, busyCode);
          check(!rejected, "R3 no reject", rejected, 0);
        end else if (src == 1) begin
          @(negedge clk); trigPin = 1'b1;
          @(posedge clk); @(posedge clk);
          @(negedge clk);
          readReg(8'h02, v);
          check(v == readyCode, "R4 not yet", v, readyCode);
          @(posedge clk); @(negedge clk);
          readReg(8'h02, v);
          check(v == busyCode, "R4 pin start", v, busyCode);
        end else begin
          @(negedge clk); trigPin = 1'b1;
          @(posedge clk); @(posedge clk);
          writeReg(8'h02, 8'h02);
          readReg(8'h02, v);
          check(v == busyCode, "R10 joint start", v, busyCode);
          check(!rejected, "R10 no reject", rejected, 0);
        end

        measureRamp(src == 0 ? "cmd" : (src == 1 ? "pin" : "both"));

        // R7 start while busy, R2 go command ignored while busy
        writeReg(8'h02, 8'h02);
        check(rejected == 1'b1, "R7 pulse busy", rejected, 1);
        readReg(8'h02, v);
        check(v == busyCode, "R7 busy kept", v, busyCode);
        check(modEn, "R7 ramp undisturbed", modEn, 1);
        writeReg(8'h02, 8'h08);
        readReg(8'h02, v);
        check(v == busyCode, "R2 ignored busy", v, busyCode);

        // R8 shutdown
        @(negedge clk); frameDone = 1'b1;
        @(posedge clk); @(negedge clk); frameDone = 1'b0;
        check(!ampEn && !modEn && bufEn, "R8 first step",
              {bufEn, ampEn, modEn}, 4);
        @(posedge clk); @(negedge clk);
        check(!bufEn, "R8 buffer off", bufEn, 0);
        readReg(8'h02, v);
        check(v == readyCode, "R8 back to ready", v, readyCode);

        // R4 held pin starts nothing
        repeat (5) begin @(posedge clk); @(negedge clk); end
        readReg(8'h02, v);
        check(v == readyCode && !bufEn, "R4 held level", v, readyCode);
        trigPin = 1'b0;
        repeat (3) begin @(posedge clk); @(negedge clk); end
      end
    end

    // R8 frame done in ready ignored
    @(negedge clk); frameDone = 1'b1;
    @(posedge clk); @(negedge clk); frameDone = 1'b0;
    readReg(8'h02, v);
    check(v == 8'h19 && !bufEn, "R8 ignored in ready", v, 8'h19);

    writeReg(8'h02, 8'h08);
    readReg(8'h02, v);
    check(v == 8'h08, "R2 go off", v, 8'h08);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule